// File: doc/BRIEF.md
# Free-Running Watchdog Reset Timer

This block supervises a CPU by means of a 7-bit count that decreases on its own. One 8-bit control word holds the count and an arm flag. Software must reload the count often enough to keep bit 6 of the count at one. If bit 6 falls to zero while the watchdog is armed, the block raises a one-cycle reset request for the chip's reset sequencer. A clock divider sets the rate of the count. It makes one tick every `PRESCALE` CPU clocks. The divider runs freely, and writes to the control word do not restart it. For that reason the real timeout lies anywhere within one tick of its nominal value.

The count runs whether or not the watchdog is armed. After a reset the watchdog is disarmed. Once software arms it, it stays armed until the next reset. Two static strap inputs choose build options. The first keeps the watchdog armed at all times, whatever the arm flag holds. The second stops a halt from triggering a reset. When the halt strap is low, a halt-entry pulse seen while the watchdog is armed forces a reset. A write that sets the arm flag and clears bit 6 gives software a way to request a reset on purpose.

Top module: `wdg_timer`

## Requirements
- R1: While `rst_n` is low and right after it is released, `ctl_rdata` reads 7Fh (arm flag clear, count 7Fh) and `wdg_rst_req` is low.
- R2: `prescale_tick` is high for one cycle in every `PRESCALE` cycles. On each tick cycle the count (bits 6:0) drops by one at the next edge and wraps from 00h to 7Fh. This happens whether or not the watchdog is armed.
- R3: A write (`wr_en` high) loads `wr_data` into the control word at the next edge. The arm flag is bit 7. A write of 0 to bit 7 leaves an armed watchdog armed.
- R4: Only `rst_n` low clears the arm flag.
- R5: While disarmed (bit 7 clear and `opt_hw_always_on` low), no count value and no write ever raises `wdg_rst_req`.
- R6: While armed, a tick that takes bit 6 from 1 to 0 raises `wdg_rst_req` for one cycle, two cycles after the tick cycle. After a reload of C0h this happens on the first tick, and after a reload of FFh on the 64th tick.
- R7: Suppose bit 6 is 1 and a write is presented with bit 7 set and bit 6 clear. Then `wdg_rst_req` is high in the second cycle after the cycle in which the write is presented.
- R8: With `opt_halt_no_reset` low, a `halt_pulse` while armed raises `wdg_rst_req` in the next cycle. A `halt_pulse` while disarmed is ignored.
- R9: With `opt_halt_no_reset` high, `halt_pulse` never raises `wdg_rst_req`.
- R10: With `opt_hw_always_on` high, the watchdog behaves as armed even when bit 7 is clear, both for the count fall and for halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Write data: bit 7 arm flag, bits 6:0 count |
| halt_pulse | input | 1 | One-cycle pulse on halt (or active-halt) entry |
| opt_hw_always_on | input | 1 | Strap: watchdog permanently armed |
| opt_halt_no_reset | input | 1 | Strap: halt does not cause a reset |
| ctl_rdata | output | 8 | Current control word |
| prescale_tick | output | 1 | One-cycle tick that advances the count |
| wdg_rst_req | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with `PRESCALE` = 4 instead of 16000. At that setting the full 64-tick timeout takes 256 clocks. A complete wrap of the count, and a timeout after a reload of FFh, can then both be run many times within the cycle budget. The timing and priority rules stay the same at any divider value, so the short setting keeps every checked path in play.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int unsigned CNT_W = 7;
    localparam int unsigned CTL_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_RESET = '1;

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } wdg_ctl_t;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int unsigned PRESCALE = 16000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE - 1);

    typedef struct packed {
        logic [PRE_W-1:0] div;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.div == LAST);
        if (tick) st_d.div = '0;
        else      st_d.div = st_q.div + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (PRESCALE > 1 && tick) |=> !tick);  // R2
endmodule

// File: rtl/wdg_ctl_reg.sv
module wdg_ctl_reg
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             tick,
    output wdg_ctl_t         ctl
);
    wdg_ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        ctl_d.armed = ctl_q.armed | (wr_en & wr_data[CTL_W-1]);
        if (wr_en)
            ctl_d.cnt = wr_data[CNT_W-1:0];
        else if (tick)
            ctl_d.cnt = ctl_q.cnt - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{armed: 1'b0, cnt: CNT_RESET};
        else        ctl_q <= ctl_d;
    end

    assign ctl = ctl_q;

    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.armed |=> ctl_q.armed);  // R4
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !tick) |=> $stable(ctl_q.cnt));  // R2
endmodule

// File: rtl/wdg_rst_gen.sv
module wdg_rst_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic msb_set,
    input  logic halt_pulse,
    input  logic opt_halt_no_reset,
    output logic rst_req
);
    typedef struct packed {
        logic expired;
        logic req;
    } gen_state_t;

    gen_state_t st_d, st_q;
    logic expired_now;
    logic halt_hit;

    always_comb begin
        st_d        = st_q;
        expired_now = armed & ~msb_set;
        halt_hit    = halt_pulse & armed & ~opt_halt_no_reset;
        st_d.expired = expired_now;
        st_d.req     = (expired_now & ~st_q.expired) | halt_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rst_req = st_q.req;

    AST_HALT_TRIGGERS: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_pulse && armed && !opt_halt_no_reset) |=> rst_req);  // R8
    AST_HALT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && $past(halt_pulse) && $past(opt_halt_no_reset)) |-> $past(armed && !msb_set));  // R9
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int unsigned PRESCALE = 16000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             halt_pulse,
    input  logic             opt_hw_always_on,
    input  logic             opt_halt_no_reset,
    output logic [CTL_W-1:0] ctl_rdata,
    output logic             prescale_tick,
    output logic             wdg_rst_req
);
    localparam int unsigned MSB = CNT_W - 1;

    wdg_ctl_t ctl;
    logic     tick;
    logic     armed_eff;

    wdg_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    wdg_ctl_reg u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .tick    (tick),
        .ctl     (ctl)
    );

    assign armed_eff = ctl.armed | opt_hw_always_on;

    wdg_rst_gen u_gen (
        .clk               (clk),
        .rst_n             (rst_n),
        .armed             (armed_eff),
        .msb_set           (ctl.cnt[MSB]),
        .halt_pulse        (halt_pulse),
        .opt_halt_no_reset (opt_halt_no_reset),
        .rst_req           (wdg_rst_req)
    );

    assign ctl_rdata     = {ctl.armed, ctl.cnt};
    assign prescale_tick = tick;

    AST_TIMEOUT_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_eff && $fell(ctl.cnt[MSB])) |=> wdg_rst_req);  // R6
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && wr_data[CTL_W-1] && !wr_data[MSB] && ctl.cnt[MSB], 2) |-> wdg_rst_req);  // R7
    AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_rst_req |-> $past(armed_eff));  // R5
endmodule

// File: tb/wdg_timer_test.sv
module wdg_timer_test;
    localparam int P = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       halt_pulse = 1'b0;
    logic       opt_hw = 1'b0;
    logic       opt_nh = 1'b0;
    logic [7:0] ctl_rdata;
    logic       prescale_tick;
    logic       wdg_rst_req;

    wdg_timer #(.PRESCALE(P)) uut (
        .clk               (clk),
        .rst_n             (rst_n),
        .wr_en             (wr_en),
        .wr_data           (wr_data),
        .halt_pulse        (halt_pulse),
        .opt_hw_always_on  (opt_hw),
        .opt_halt_no_reset (opt_nh),
        .ctl_rdata         (ctl_rdata),
        .prescale_tick     (prescale_tick),
        .wdg_rst_req       (wdg_rst_req)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    int errors = 0;
    int checks = 0;
    int exp_q[$];
    string tag_q[$];
    string cur_tag = "R5";

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expected pulses and compares
    always @(negedge clk) begin
        if (rst_n) begin
            while (exp_q.size() > 0 && exp_q[0] < cyc) begin
                checks++; errors++;
                $display("FAIL %s: missing reset request, actual=none expected cycle=%0d", tag_q[0], exp_q[0]);
                void'(exp_q.pop_front()); void'(tag_q.pop_front());
            end
            if (wdg_rst_req) begin
                checks++;
                if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                    void'(exp_q.pop_front()); void'(tag_q.pop_front());
                end else begin
                    errors++;
                    $display("FAIL %s: unexpected reset request, actual cycle=%0d expected=%0d",
                             (tag_q.size() > 0) ? tag_q[0] : cur_tag, cyc,
                             (exp_q.size() > 0) ? exp_q[0] : -1);
                end
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_pulse(string tag, int at);
        exp_q.push_back(at);
        tag_q.push_back(tag);
    endtask

    task automatic drain(string tag);
        repeat (4) @(negedge clk);
        check(tag, exp_q.size(), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", ctl_rdata, 8'h7F);
        check("R1", wdg_rst_req, 0);
        rst_n = 1'b1;
    endtask

    task automatic write_ctl(logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_ticks(int n);
        int k = 0;
        while (1) begin
            if (prescale_tick) begin
                k++;
                if (k == n) break;
            end
            @(negedge clk);
        end
    endtask

    task automatic halt_now();
        @(negedge clk);
        halt_pulse = 1'b1;
        @(negedge clk);
        halt_pulse = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int t0;
        // R1 reset state
        do_reset();
        check("R1", ctl_rdata, 8'h7F);

        // R2 tick spacing
        @(negedge clk);
        while (!prescale_tick) @(negedge clk);
        t0 = cyc;
        @(negedge clk);
        while (!prescale_tick) @(negedge clk);
        check("R2", cyc - t0, P);

        // R5 disarmed: write with bit6 clear, no request; R2 wrap
        do_reset();
        cur_tag = "R5";
        write_ctl(8'h05);
        check("R3", ctl_rdata, 8'h05);
        wait_ticks(6);
        @(negedge clk);
        check("R2", ctl_rdata, 8'h7F);
        wait_ticks(70);
        @(negedge clk);
        check("R2", ctl_rdata, 8'h39);
        drain("R5");

        // R6 arm with C0h: request after first tick
        cur_tag = "R6";
        write_ctl(8'hC0);
        check("R3", ctl_rdata, 8'hC0);
        wait_ticks(1);
        expect_pulse("R6", cyc + 2);
        drain("R6");

        // R3 sticky arm: write bit7=0, then FFh timeout via 64 ticks
        write_ctl(8'h7F);
        check("R3", ctl_rdata, 8'hFF);
        wait_ticks(64);
        expect_pulse("R6", cyc + 2);
        drain("R6");

        // R4 reset clears arm
        do_reset();
        check("R4", ctl_rdata, 8'h7F);

        // R7 software reset
        cur_tag = "R7";
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'hBF;
        @(negedge clk);
        wr_en = 1'b0;
        expect_pulse("R7", cyc + 1);
        drain("R7");

        // R8 halt while armed
        do_reset();
        cur_tag = "R8";
        halt_now();
        drain("R8");
        write_ctl(8'hFF);
        @(negedge clk);
        halt_pulse = 1'b1;
        expect_pulse("R8", cyc + 1);
        @(negedge clk);
        halt_pulse = 1'b0;
        drain("R8");

        // R9 halt masked by strap
        do_reset();
        cur_tag = "R9";
        opt_nh = 1'b1;
        write_ctl(8'hFF);
        halt_now();
        drain("R9");
        opt_nh = 1'b0;

        // R10 hardware always-on
        opt_hw = 1'b1;
        do_reset();
        cur_tag = "R10";
        wait_ticks(64);
        expect_pulse("R10", cyc + 2);
        drain("R10");
        check("R10", ctl_rdata[7], 0);
        @(negedge clk);
        halt_pulse = 1'b1;
        expect_pulse("R10", cyc + 1);
        @(negedge clk);
        halt_pulse = 1'b0;
        drain("R10");
        opt_hw = 1'b0;
        do_reset();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule